// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a test access port controller for a wide synchronous memory die. It is driven by a test clock, a mode-select line and a serial data input, and it returns one serial data output. There is no dedicated test reset pin. A chip power-on reset puts the controller in its reset state. After that, holding the mode-select line high brings it back to that state from anywhere.

Behind the standard sixteen-state controller there are four scan paths: a 3-bit instruction register, a 1-bit bypass cell, a 32-bit identification word and a 70-cell boundary register. The instruction set is small. There are two sample instructions (one of them also tri-states the data drivers), an identification read, a bypass and a reserved code. Nothing is ever driven onto the pads from the scan chain, and an update of a data register has no effect.

Top module: `scan_tap`

## Requirements
- R1: After power-on reset, `tdo_en` and `drv_hiz` are 0 and the active instruction is the ID read (opcode 001). A first data scan therefore returns the 32-bit ID word, LSB first, with these fields: [31:28]=0000, [27:18]=0011100100, [17:12]=vendor field (default 000000), [11:1]=00000000111, [0]=1.
- R2: Five consecutive rising `tck` edges with `tms`=1 put the controller in Test-Logic-Reset from any of the 16 states. On the next edge the active instruction returns to 001.
- R3: In Capture-IR the instruction shift register loads binary 001, and this value is shifted out LSB first. Shifted-in opcode bits also enter LSB first.
- R4: Opcode 001 selects the 32-bit ID register, which loads the ID word in Capture-DR.
- R5: Opcodes 011, 101 and 111 select the 1-bit bypass cell. It captures 0, so a scan output is the input delayed by one bit.
- R6: Opcode 100 selects the 70-cell boundary register, which captures `pad_in` in Capture-DR. Cell index 0 leaves on `tdo` first. `drv_hiz` stays 0.
- R7: Opcodes 000 and 010 capture the boundary register exactly as R6 does. They also hold `drv_hiz` at 1 from the Update-IR that loads them until another instruction is loaded or Test-Logic-Reset is entered.
- R8: Opcode 110 is reserved. It selects the 1-bit bypass cell and leaves `drv_hiz` at 0.
- R9: Boundary indices 53 and 54 are place-holder cells. They capture 0 whatever `pad_in` holds.
- R10: `tdo_en` is 1 only while the controller is in Shift-DR or Shift-IR. `tdo` and `tdo_en` change only on falling `tck` edges.
- R11: The active instruction (and hence `drv_hiz`) changes only on the edge that leaves Update-IR, or on entry to or during Test-Logic-Reset. Shifting a new opcode and parking in Pause-IR leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Chip power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| pad_in | input | 70 | Pad values offered to the boundary cells, index 0 first out |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo`; 0 means high impedance |
| drv_hiz | output | 1 | Request to the core to tri-state its data drivers |

## Verification
The interaction that matters most is between the return to Test-Logic-Reset on five high `tms` edges and a pending instruction update. If the controller is in the Update-IR column when the five ones begin, a freshly shifted opcode can become active and be cleared again within a few edges. The bench walks a 22-step path that visits all sixteen states and cuts it at every prefix length before applying the five ones. Each time, it loads the ID read and confirms the result at the ports with a full ID scan. A second overlap is on the Capture-to-Shift edge: the capture load and the first output bit fall within the same half-period. This is judged by checking that the first sampled `tdo` of every scan equals the captured bit 0, for all eight opcodes.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] IR_CAPTURE_PATTERN = 3'b001;
    localparam logic [IR_W-1:0] OP_IDCODE          = 3'b001;

    localparam logic [3:0]  ID_REV     = 4'b0000;
    localparam logic [9:0]  ID_DENSITY = 10'b0011100100;
    localparam logic [10:0] ID_MFR     = 11'b00000000111;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SHF_DR = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SHF_IR = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_BND = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     hiz;
    } op_dec_t;

    typedef struct packed {
        logic tdo;
        logic en;
    } tdo_regs_t;

    // Opcode map: the two sample-with-tristate codes, ID read, sample,
    // reserved code and the aliased bypass codes.
    function automatic op_dec_t decode_op(input logic [IR_W-1:0] op);
        op_dec_t r;
        r.path = PATH_BYP;
        r.hiz  = 1'b0;
        case (op)
            3'b000, 3'b010: begin
                r.path = PATH_BND;
                r.hiz  = 1'b1;
            end
            3'b001:  r.path = PATH_ID;
            3'b100:  r.path = PATH_BND;
            3'b110:  r.path = PATH_BYP;   // reserved: harmless one-bit path
            default: r.path = PATH_BYP;   // 011, 101, 111
        endcase
        return r;
    endfunction

    function automatic logic is_shift(input tap_state_e s);
        return (s == ST_SHF_DR) || (s == ST_SHF_IR);
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e st
);

    tap_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RESET:  st_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   st_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: st_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: st_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: st_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: st_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: st_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign st = st_q;

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      st,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_cur,
    output logic [IR_W-1:0] ir_sh,
    output logic            ir_so
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] cur;
    } ir_regs_t;

    ir_regs_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (st)
            ST_RESET:  ir_d.cur = OP_IDCODE;
            ST_CAP_IR: ir_d.sh  = IR_CAPTURE_PATTERN;
            ST_SHF_IR: ir_d.sh  = {tdi, ir_q.sh[IR_W-1:1]};
            ST_UPD_IR: ir_d.cur = ir_q.sh;
            default:   ir_d     = ir_q;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_q.sh  <= '0;
            ir_q.cur <= OP_IDCODE;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign ir_cur = ir_q.cur;
    assign ir_sh  = ir_q.sh;
    assign ir_so  = ir_q.sh[0];

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int                BSR_W   = 70,
    parameter logic [BSR_W-1:0]  PH_MASK = '0,
    parameter logic [ID_W-1:0]   ID_WORD = '0
) (
    input  logic             tck,
    input  logic             por_n,
    input  tap_state_e       st,
    input  dr_path_e         path,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pad_in,
    output logic             dr_so,
    output logic [BSR_W-1:0] bsr_sh,
    output logic [ID_W-1:0]  id_sh
);

    typedef struct packed {
        logic [BSR_W-1:0] bsr;
        logic [ID_W-1:0]  id;
        logic             byp;
    } dr_regs_t;

    dr_regs_t         dr_d, dr_q;
    logic [BSR_W-1:0] cap_val;

    // Place-holder cells are tied low; every other cell samples its pad.
    for (genvar i = 0; i < BSR_W; i++) begin : g_cell
        assign cap_val[i] = PH_MASK[i] ? 1'b0 : pad_in[i];
    end

    always_comb begin
        dr_d = dr_q;
        if (st == ST_CAP_DR) begin
            case (path)
                PATH_BND: dr_d.bsr = cap_val;
                PATH_ID:  dr_d.id  = ID_WORD;
                default:  dr_d.byp = 1'b0;
            endcase
        end else if (st == ST_SHF_DR) begin
            case (path)
                PATH_BND: dr_d.bsr = {tdi, dr_q.bsr[BSR_W-1:1]};
                PATH_ID:  dr_d.id  = {tdi, dr_q.id[ID_W-1:1]};
                default:  dr_d.byp = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) dr_q <= '0;
        else        dr_q <= dr_d;
    end

    always_comb begin
        case (path)
            PATH_BND: dr_so = dr_q.bsr[0];
            PATH_ID:  dr_so = dr_q.id[0];
            default:  dr_so = dr_q.byp;
        endcase
    end

    assign bsr_sh = dr_q.bsr;
    assign id_sh  = dr_q.id;

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int               BSR_W        = 70,
    parameter logic [BSR_W-1:0] PH_MASK      = {{(BSR_W-2){1'b0}}, 2'b11} << 53,
    parameter logic [5:0]       VENDOR_FIELD = 6'b000000
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pad_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic             drv_hiz
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DENSITY, VENDOR_FIELD, ID_MFR, 1'b1};

    tap_state_e       tap_st;
    logic [IR_W-1:0]  ir_cur;
    logic [IR_W-1:0]  ir_sh;
    logic             ir_so;
    logic             dr_so;
    logic [BSR_W-1:0] bsr_sh;
    logic [ID_W-1:0]  id_sh;
    op_dec_t          op_dec;
    dr_path_e         dr_path;
    tdo_regs_t        out_d, out_q;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .st    (tap_st)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .por_n  (por_n),
        .st     (tap_st),
        .tdi    (tdi),
        .ir_cur (ir_cur),
        .ir_sh  (ir_sh),
        .ir_so  (ir_so)
    );

    assign op_dec  = decode_op(ir_cur);
    assign dr_path = op_dec.path;

    scan_tap_dr #(
        .BSR_W   (BSR_W),
        .PH_MASK (PH_MASK),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck    (tck),
        .por_n  (por_n),
        .st     (tap_st),
        .path   (dr_path),
        .tdi    (tdi),
        .pad_in (pad_in),
        .dr_so  (dr_so),
        .bsr_sh (bsr_sh),
        .id_sh  (id_sh)
    );

    // Test-Logic-Reset releases the drivers at once, before the
    // instruction register itself is reloaded.
    assign drv_hiz = op_dec.hiz && (tap_st != ST_RESET);

    always_comb begin
        out_d.en  = is_shift(tap_st);
        out_d.tdo = 1'b0;
        if (tap_st == ST_SHF_IR)      out_d.tdo = ir_so;
        else if (tap_st == ST_SHF_DR) out_d.tdo = dr_so;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_en = out_q.en;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
#(
    parameter int               BSR_W   = 70,
    parameter logic [BSR_W-1:0] PH_MASK = '0,
    parameter logic [ID_W-1:0]  ID_WORD = '0
) (
    input logic             tck,
    input logic             por_n,
    input logic             tms,
    input logic             tdo_en,
    input logic             drv_hiz,
    input tap_state_e       st,
    input logic [IR_W-1:0]  ir_sh,
    input dr_path_e         path,
    input logic [ID_W-1:0]  id_sh,
    input logic [BSR_W-1:0] bsr_sh
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)              ones_q <= 3'd0;
        else if (!tms)           ones_q <= 3'd0;
        else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
        (ones_q >= 3'd5) |-> (st == ST_RESET)); // R2

    AST_IR_CAPTURE_001: assert property (@(posedge tck) disable iff (!por_n)
        (st == ST_CAP_IR) |=> (ir_sh == 3'b001)); // R3

    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
        (st == ST_CAP_DR && path == PATH_ID) |=> (id_sh == ID_WORD)); // R4

    AST_PLACEHOLDER_ZERO: assert property (@(posedge tck) disable iff (!por_n)
        (st == ST_CAP_DR && path == PATH_BND) |=> ((bsr_sh & PH_MASK) == '0)); // R9

    AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en == (st == ST_SHF_DR || st == ST_SHF_IR)); // R10

    AST_HIZ_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(drv_hiz) |->
            ($past(st) == ST_UPD_IR || $past(st) == ST_RESET || st == ST_RESET)); // R11

endmodule

bind scan_tap scan_tap_chk #(
    .BSR_W   (BSR_W),
    .PH_MASK (PH_MASK),
    .ID_WORD (ID_WORD)
) u_chk (
    .tck     (tck),
    .por_n   (por_n),
    .tms     (tms),
    .tdo_en  (tdo_en),
    .drv_hiz (drv_hiz),
    .st      (tap_st),
    .ir_sh   (ir_sh),
    .path    (dr_path),
    .id_sh   (id_sh),
    .bsr_sh  (bsr_sh)
);

// File: tb/scan_tap_tb.sv
module scan_tap_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BW = 70;
    localparam logic [31:0] EXP_ID =
        {4'b0000, 10'b0011100100, 6'b000000, 11'b00000000111, 1'b1};
    localparam logic [127:0] PH_BITS = (128'd1 << 53) | (128'd1 << 54);
    // TMS walk from Run-Test/Idle that visits all sixteen states, bit 0 first.
    localparam logic [21:0] WALK = 22'b1111101010011110101001;

    logic          tck = 1'b0;
    logic          por_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] pad_in = '0;
    logic          tdo;
    logic          tdo_en;
    logic          drv_hiz;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    scan_tap u_dut (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .tdi     (tdi),
        .pad_in  (pad_in),
        .tdo     (tdo),
        .tdo_en  (tdo_en),
        .drv_hiz (drv_hiz)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Entered just after a falling edge; returns just after the next one.
    task automatic tick(input logic m, input logic d);
        logic pre;
        tms = m;
        tdi = d;
        pre = tdo;
        @(posedge tck);
        #1;
        check(tdo === pre, "R10 tdo moved on rising edge", {127'd0, tdo}, {127'd0, pre});
        @(negedge tck);
        #1;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        check(tdo_en === 1'b1, "R10 tdo_en in Shift-IR", {127'd0, tdo_en}, 128'd1);
        cap[0] = tdo;
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, op[i]);
            if (i < 2) cap[i+1] = tdo;
        end
        check(tdo_en === 1'b0, "R10 tdo_en in Exit1-IR", {127'd0, tdo_en}, 128'd0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        check(tdo_en === 1'b1, "R10 tdo_en in Shift-DR", {127'd0, tdo_en}, 128'd1);
        dout[0] = tdo;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            if (i < n - 1) dout[i+1] = tdo;
        end
        check(tdo_en === 1'b0, "R10 tdo_en in Exit1-DR", {127'd0, tdo_en}, 128'd0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    function automatic logic [127:0] expect_scan(input int len, input logic [127:0] cap,
                                                 input logic [127:0] din, input int n);
        logic [127:0] lo;
        logic [127:0] r;
        lo = (128'd1 << len) - 128'd1;
        r  = (cap & lo) | (din << len);
        return r & ((128'd1 << n) - 128'd1);
    endfunction

    initial begin
        logic [127:0] dout;
        logic [127:0] din;
        logic [127:0] cap_exp;
        logic [2:0]   ircap;
        logic [2:0]   op;
        int           len;
        bit           hiz_exp;

        repeat (2) @(negedge tck);
        #1;
        por_n = 1'b1;

        // R1: reset state and first ID scan
        check(tdo_en === 1'b0, "R1 tdo_en after reset", {127'd0, tdo_en}, 128'd0);
        check(drv_hiz === 1'b0, "R1 drv_hiz after reset", {127'd0, drv_hiz}, 128'd0);
        tick(1'b0, 1'b0);
        scan_dr(32, 128'd0, dout);
        check(dout[31:0] === EXP_ID, "R1 ID after reset", dout, {96'd0, EXP_ID});

        // Opcode sweep: R3 capture, R4..R8 path length, capture and hiz
        pad_in = {6'h2A, 64'h5A5A_C3C3_0F0F_1234};
        din    = {64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98};
        for (int k = 0; k < 8; k++) begin
            op = k[2:0];
            load_ir(op, ircap);
            check(ircap === 3'b001, "R3 IR capture pattern", {125'd0, ircap}, 128'd1);
            hiz_exp = (op == 3'b000) || (op == 3'b010);
            check(drv_hiz === hiz_exp,
                  hiz_exp ? "R7 drv_hiz for sample-tristate" : "R6 R8 drv_hiz low",
                  {127'd0, drv_hiz}, {127'd0, hiz_exp});
            if (op == 3'b001) begin
                len = 32; cap_exp = {96'd0, EXP_ID};
            end else if (op == 3'b000 || op == 3'b010 || op == 3'b100) begin
                len = 70; cap_exp = {58'd0, pad_in} & ~PH_BITS;
            end else begin
                len = 1; cap_exp = 128'd0;
            end
            scan_dr(110, din, dout);
            if (op == 3'b001)
                check(dout === expect_scan(len, cap_exp, din, 110), "R4 ID path", dout,
                      expect_scan(len, cap_exp, din, 110));
            else if (op == 3'b100)
                check(dout === expect_scan(len, cap_exp, din, 110), "R6 sample path", dout,
                      expect_scan(len, cap_exp, din, 110));
            else if (op == 3'b000 || op == 3'b010)
                check(dout === expect_scan(len, cap_exp, din, 110), "R7 sample-tristate path",
                      dout, expect_scan(len, cap_exp, din, 110));
            else if (op == 3'b110)
                check(dout === expect_scan(len, cap_exp, din, 110), "R8 reserved path", dout,
                      expect_scan(len, cap_exp, din, 110));
            else
                check(dout === expect_scan(len, cap_exp, din, 110), "R5 bypass path", dout,
                      expect_scan(len, cap_exp, din, 110));
        end

        // R6/R9: boundary ordering and place-holder cells under several pad patterns
        load_ir(3'b100, ircap);
        for (int p = 0; p < 5; p++) begin
            case (p)
                0: pad_in = '1;
                1: pad_in = {35{2'b10}};
                2: pad_in = 70'd1;
                3: pad_in = 70'd1 << 69;
                default: pad_in = {35{2'b01}};
            endcase
            scan_dr(70, 128'd0, dout);
            cap_exp = {58'd0, pad_in} & ~PH_BITS;
            check(dout === cap_exp, "R6 boundary order", dout, cap_exp);
            check(dout[54:53] === 2'b00, "R9 place-holder cells", {126'd0, dout[54:53]}, 128'd0);
        end

        // R11: a shifted opcode parked in Pause-IR does not take effect
        load_ir(3'b000, ircap);
        check(drv_hiz === 1'b1, "R7 drv_hiz after load", {127'd0, drv_hiz}, 128'd1);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        check(drv_hiz === 1'b1, "R11 hiz held in Pause-IR", {127'd0, drv_hiz}, 128'd1);
        check(tdo_en === 1'b0, "R10 tdo_en in Pause-IR", {127'd0, tdo_en}, 128'd0);
        tick(1'b0, 1'b0);
        check(drv_hiz === 1'b1, "R11 hiz still held", {127'd0, drv_hiz}, 128'd1);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        check(drv_hiz === 1'b0, "R11 hiz cleared after update", {127'd0, drv_hiz}, 128'd0);
        scan_dr(8, 128'hA5, dout);
        check(dout === expect_scan(1, 128'd0, 128'hA5, 8), "R5 bypass after update", dout,
              expect_scan(1, 128'd0, 128'hA5, 8));

        // R2: five TMS-high edges from every prefix of the walk
        for (int k = 0; k <= 22; k++) begin
            to_idle();
            load_ir(3'b010, ircap);
            for (int i = 0; i < k; i++) tick(WALK[i], 1'b1);
            for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
            check(drv_hiz === 1'b0, "R2 drivers released in reset", {127'd0, drv_hiz}, 128'd0);
            check(tdo_en === 1'b0, "R2 tdo_en off in reset", {127'd0, tdo_en}, 128'd0);
            tick(1'b0, 1'b0);
            scan_dr(32, 128'd0, dout);
            check(dout[31:0] === EXP_ID, "R2 ID after five ones", dout, {96'd0, EXP_ID});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule